// File: doc/BRIEF.md
# Shared-Memory Ownership Status Byte

This block implements one reserved status byte that lives inside a small RAM shared by a serial port and a parallel byte-wide port. Software on the two sides uses it to agree on who owns the RAM. The block checks each port's address against the reserved location, which sits either at address zero or at the all-ones address depending on a location-select input. A write that hits that location updates only the field that belongs to the writing port. A read that hits it returns the full byte. Any other read passes the RAM's own read data through unchanged.

The top three bits of the byte hold a 3-bit serial bit counter, and neither port can write them. The counter advances by one for each serial bit shift. When it wraps from seven back to zero, the block issues a one-cycle RAM access strobe for the serial side. This strobe does not depend on the ownership bits. Reading the counter therefore tells parallel software how soon the serial port's next fixed-slot access will come.

The byte layout, from the most significant bit down, is:

- counter bits [7:5]
- serial-owned bits [4:2], where bit 4 is the serial claim flag
- parallel-owned bits [1:0], where bit 1 is the parallel claim flag

Top module: `ownb_top`

## Requirements
- R1: The reserved byte is at address 0 when `loc_sel` is 0 and at the all-ones address when `loc_sel` is 1. Accesses to any other address neither read nor write the byte.
- R2: A read strobe produces registered read data one cycle later. If the address hits the reserved byte, the data is the full 8-bit status byte. Otherwise it is the port's RAM data input. A read in the same cycle as a write to the byte returns the value from before the write.
- R3: A serial write to the reserved byte updates only bits [4:2]. Bits [1:0] and [7:5] are unaffected.
- R4: A parallel write to the reserved byte updates only bits [1:0]. Bits [7:2] are unaffected.
- R5: Counter bits [7:5] ignore writes from both ports.
- R6: The counter increments by one on each cycle with `ser_shift_en` high, wraps from 7 to 0, and holds otherwise.
- R7: `ser_ram_stb` is high for exactly one cycle, in the cycle the counter first shows 0 after a 7-to-0 wrap, and is low at all other times.
- R8: When both ports write the reserved byte in the same cycle, both masked updates take effect.
- R9: Reset (synchronous, active high) clears the counter, all status bits, both read data outputs and the strobe.
- R10: The counter and the strobe run the same way whatever values the ownership bits hold, including parallel claim 1 with serial claim 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_sel | input | 1 | Reserved-byte location: 0 = address zero, 1 = all-ones address |
| ser_shift_en | input | 1 | One serial bit shifted this cycle |
| ser_addr | input | 19 | Serial port address |
| ser_wdata | input | 8 | Serial port write data |
| ser_wr | input | 1 | Serial port write strobe |
| ser_rd | input | 1 | Serial port read strobe |
| ser_mem_q | input | 8 | RAM read data for the serial port |
| par_addr | input | 19 | Parallel port address |
| par_wdata | input | 8 | Parallel port write data |
| par_wr | input | 1 | Parallel port write strobe |
| par_rd | input | 1 | Parallel port read strobe |
| par_mem_q | input | 8 | RAM read data for the parallel port |
| ser_rdata | output | 8 | Registered serial read data |
| par_rdata | output | 8 | Registered parallel read data |
| ser_ram_stb | output | 1 | Serial fixed-slot RAM access strobe |

## Verification
All-ones and mixed write patterns are driven from each port in turn. Reading the byte back from the other port then shows whether the write mask lets a stray bit through into a foreign field or into the counter. Simultaneous writes tell apart a design that merges both updates from one that lets one port win. Moving `loc_sel` while writing and reading at address zero and at the all-ones address separates a correct decoder from one fixed to a single location. Shifting through a full eight-bit cycle while the parallel claim is set checks that the strobe lands only on the wrap and ignores ownership.

// File: rtl/ownb_pkg.sv
package ownb_pkg;
  localparam int NPORT    = 2;
  localparam int PORT_SER = 0;
  localparam int PORT_PAR = 1;
endpackage

// File: rtl/ownb_addr_match.sv
module ownb_addr_match #(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              loc_sel,
  output logic              hit
);
  // reserved location is all zeros or all ones, following loc_sel
  assign hit = (addr == {ADDR_W{loc_sel}});
endmodule

// File: rtl/ownb_slot_cnt.sv
module ownb_slot_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             stb_q
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= shift_en && (cnt_q == CNT_LAST);
      if (shift_en) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ownb_fields.sv
module ownb_fields #(
  parameter int SER_W = 3,
  parameter int PAR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_we,
  input  logic [SER_W-1:0] ser_field,
  input  logic             par_we,
  input  logic [PAR_W-1:0] par_field,
  output logic [SER_W-1:0] s_q,
  output logic [PAR_W-1:0] b_q
);
  // disjoint fields: both updates can land in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0;
      b_q <= '0;
    end else begin
      if (ser_we) s_q <= ser_field;
      if (par_we) b_q <= par_field;
    end
  end
endmodule

// File: rtl/ownb_rd_port.sv
module ownb_rd_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              hit,
  input  logic [BYTE_W-1:0] stat,
  input  logic [BYTE_W-1:0] mem_q,
  output logic [BYTE_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= hit ? stat : mem_q;
  end
endmodule

// File: rtl/ownb_top.sv
module ownb_top
  import ownb_pkg::*;
#(
  parameter  int ADDR_W = 19,
  parameter  int CNT_W  = 3,
  parameter  int SER_W  = 3,
  parameter  int PAR_W  = 2,
  localparam int BYTE_W = CNT_W + SER_W + PAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_sel,
  input  logic              ser_shift_en,
  input  logic [ADDR_W-1:0] ser_addr,
  input  logic [BYTE_W-1:0] ser_wdata,
  input  logic              ser_wr,
  input  logic              ser_rd,
  input  logic [BYTE_W-1:0] ser_mem_q,
  input  logic [ADDR_W-1:0] par_addr,
  input  logic [BYTE_W-1:0] par_wdata,
  input  logic              par_wr,
  input  logic              par_rd,
  input  logic [BYTE_W-1:0] par_mem_q,
  output logic [BYTE_W-1:0] ser_rdata,
  output logic [BYTE_W-1:0] par_rdata,
  output logic              ser_ram_stb
);
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic [BYTE_W-1:0] p_memq  [NPORT];
  logic              p_rd    [NPORT];
  logic              p_hit   [NPORT];
  logic [BYTE_W-1:0] p_rdata [NPORT];

  logic [CNT_W-1:0]  cnt_q;
  logic [SER_W-1:0]  s_q;
  logic [PAR_W-1:0]  b_q;
  logic [BYTE_W-1:0] stat_byte;
  logic              ser_hit, par_hit, ser_we, par_we;
  logic              unused_wbits;

  assign p_addr[PORT_SER] = ser_addr;
  assign p_addr[PORT_PAR] = par_addr;
  assign p_memq[PORT_SER] = ser_mem_q;
  assign p_memq[PORT_PAR] = par_mem_q;
  assign p_rd[PORT_SER]   = ser_rd;
  assign p_rd[PORT_PAR]   = par_rd;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    ownb_addr_match #(.ADDR_W(ADDR_W)) u_match (
      .addr    (p_addr[g]),
      .loc_sel (loc_sel),
      .hit     (p_hit[g])
    );
    ownb_rd_port #(.BYTE_W(BYTE_W)) u_rd (
      .clk   (clk),
      .rst   (rst),
      .rd    (p_rd[g]),
      .hit   (p_hit[g]),
      .stat  (stat_byte),
      .mem_q (p_memq[g]),
      .rdata (p_rdata[g])
    );
  end

  assign ser_hit   = p_hit[PORT_SER];
  assign par_hit   = p_hit[PORT_PAR];
  assign ser_we    = ser_wr && ser_hit;
  assign par_we    = par_wr && par_hit;
  assign ser_rdata = p_rdata[PORT_SER];
  assign par_rdata = p_rdata[PORT_PAR];

  ownb_slot_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .shift_en (ser_shift_en),
    .cnt_q    (cnt_q),
    .stb_q    (ser_ram_stb)
  );

  ownb_fields #(.SER_W(SER_W), .PAR_W(PAR_W)) u_fields (
    .clk       (clk),
    .rst       (rst),
    .ser_we    (ser_we),
    .ser_field (ser_wdata[PAR_W +: SER_W]),
    .par_we    (par_we),
    .par_field (par_wdata[0 +: PAR_W]),
    .s_q       (s_q),
    .b_q       (b_q)
  );

  assign stat_byte = {cnt_q, s_q, b_q};

  // write bits outside each port's own field are dropped by design
  assign unused_wbits = ^{ser_wdata[BYTE_W-1 -: CNT_W], ser_wdata[PAR_W-1:0],
                          par_wdata[BYTE_W-1:PAR_W]};
endmodule

// File: rtl/ownb_chk.sv
module ownb_chk #(
  parameter int CNT_W  = 3,
  parameter int SER_W  = 3,
  parameter int PAR_W  = 2,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_en,
  input logic              stb,
  input logic [CNT_W-1:0]  cnt,
  input logic [SER_W-1:0]  s_bits,
  input logic [PAR_W-1:0]  b_bits,
  input logic              ser_we,
  input logic              par_we,
  input logic              par_rd,
  input logic              par_hit,
  input logic [BYTE_W-1:0] par_rdata
);
  localparam logic [CNT_W-1:0] LAST = '1;

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (cnt == '0 && s_bits == '0 && b_bits == '0 && !stb));

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> cnt == $past(cnt) + 1'b1);

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cnt));

  assert_stb_on_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (shift_en && cnt == LAST) |=> stb);

  assert_stb_only_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    stb |-> (cnt == '0 && $past(shift_en)));

  assert_ser_field_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ser_we |=> $stable(s_bits));

  assert_par_field_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !par_we |=> $stable(b_bits));

  assert_par_read_R2: assert property (@(posedge clk) disable iff (rst)
    (par_rd && par_hit) |=> par_rdata == $past({cnt, s_bits, b_bits}));
endmodule

bind ownb_top ownb_chk #(
  .CNT_W(CNT_W), .SER_W(SER_W), .PAR_W(PAR_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_en  (ser_shift_en),
  .stb       (ser_ram_stb),
  .cnt       (cnt_q),
  .s_bits    (s_q),
  .b_bits    (b_q),
  .ser_we    (ser_we),
  .par_we    (par_we),
  .par_rd    (par_rd),
  .par_hit   (par_hit),
  .par_rdata (par_rdata)
);

// File: tb/tb_ownb_top.sv
module tb_ownb_top;
  localparam int AW = 19;
  localparam logic [AW-1:0] A_LO = '0;
  localparam logic [AW-1:0] A_HI = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc_sel = 1'b0, ser_shift_en = 1'b0;
  logic [AW-1:0] ser_addr = '0, par_addr = '0;
  logic [7:0] ser_wdata = '0, par_wdata = '0, ser_mem_q = 8'h00, par_mem_q = 8'h00;
  logic ser_wr = 1'b0, ser_rd = 1'b0, par_wr = 1'b0, par_rd = 1'b0;
  logic [7:0] ser_rdata, par_rdata;
  logic ser_ram_stb;

  int total = 0, bad = 0;
  logic [2:0] exp_c = '0, exp_s = '0;
  logic [1:0] exp_b = '0;

  always #2 clk = ~clk;

  ownb_top dut (
    .clk(clk), .rst(rst), .loc_sel(loc_sel), .ser_shift_en(ser_shift_en),
    .ser_addr(ser_addr), .ser_wdata(ser_wdata), .ser_wr(ser_wr), .ser_rd(ser_rd),
    .ser_mem_q(ser_mem_q), .par_addr(par_addr), .par_wdata(par_wdata),
    .par_wr(par_wr), .par_rd(par_rd), .par_mem_q(par_mem_q),
    .ser_rdata(ser_rdata), .par_rdata(par_rdata), .ser_ram_stb(ser_ram_stb)
  );

  function automatic logic [7:0] exp_byte();
    return {exp_c, exp_s, exp_b};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ser_write(input logic [AW-1:0] a, input logic [7:0] d);
    ser_addr = a; ser_wdata = d; ser_wr = 1'b1;
    cyc();
    ser_wr = 1'b0;
  endtask

  task automatic par_write(input logic [AW-1:0] a, input logic [7:0] d);
    par_addr = a; par_wdata = d; par_wr = 1'b1;
    cyc();
    par_wr = 1'b0;
  endtask

  task automatic ser_read(input logic [AW-1:0] a, output logic [7:0] q);
    ser_addr = a; ser_rd = 1'b1;
    cyc();
    ser_rd = 1'b0;
    q = ser_rdata;
  endtask

  task automatic par_read(input logic [AW-1:0] a, output logic [7:0] q);
    par_addr = a; par_rd = 1'b1;
    cyc();
    par_rd = 1'b0;
    q = par_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R9 ser_rdata after reset", ser_rdata, 8'h00);
    chk("R9 par_rdata after reset", par_rdata, 8'h00);
    chk("R9 strobe after reset", {7'd0, ser_ram_stb}, 8'h00);
    par_read(A_LO, q);
    chk("R9 status byte after reset", q, 8'h00);
  endtask

  task automatic t_ser_mask();
    logic [7:0] q;
    ser_write(A_LO, 8'hFF);
    exp_s = 3'b111;
    par_read(A_LO, q);
    chk("R3 R5 serial all-ones write", q, exp_byte());
    ser_write(A_LO, 8'hA5);
    exp_s = 3'b001;
    ser_read(A_LO, q);
    chk("R3 serial mixed write", q, exp_byte());
  endtask

  task automatic t_par_mask();
    logic [7:0] q;
    par_write(A_LO, 8'hFF);
    exp_b = 2'b11;
    ser_read(A_LO, q);
    chk("R4 R5 parallel all-ones write", q, exp_byte());
    par_write(A_LO, 8'hFE);
    exp_b = 2'b10;
    par_read(A_LO, q);
    chk("R4 parallel mixed write", q, exp_byte());
  endtask

  task automatic t_simul();
    logic [7:0] q;
    ser_addr = A_LO; ser_wdata = 8'h14; ser_wr = 1'b1;
    par_addr = A_LO; par_wdata = 8'h01; par_wr = 1'b1;
    cyc();
    ser_wr = 1'b0; par_wr = 1'b0;
    exp_s = 3'b101; exp_b = 2'b01;
    par_read(A_LO, q);
    chk("R8 simultaneous writes", q, exp_byte());
  endtask

  task automatic t_loc();
    logic [7:0] q;
    loc_sel = 1'b1;
    ser_mem_q = 8'h3C; par_mem_q = 8'hC3;
    ser_write(A_LO, 8'h00);
    par_write(A_LO, 8'h00);
    ser_read(A_LO, q);
    chk("R1 non-reserved read gives RAM data", q, 8'h3C);
    par_read(A_HI, q);
    chk("R1 byte moved to all-ones, writes at zero ignored", q, exp_byte());
    ser_write(A_HI, 8'h08);
    exp_s = 3'b010;
    par_read(A_HI, q);
    chk("R1 write at all-ones hits", q, exp_byte());
    par_read(AW'(5), q);
    chk("R1 other address gives RAM data", q, 8'hC3);
    loc_sel = 1'b0;
    ser_read(A_HI, q);
    chk("R1 all-ones not reserved when loc_sel=0", q, 8'h3C);
  endtask

  task automatic t_rd_old();
    logic [7:0] old;
    old = exp_byte();
    par_addr = A_LO; par_wdata = 8'h02; par_wr = 1'b1; par_rd = 1'b1;
    cyc();
    par_wr = 1'b0; par_rd = 1'b0;
    exp_b = 2'b10;
    chk("R2 read with write returns old value", par_rdata, old);
    ser_write(A_LO, 8'h00);
    exp_s = 3'b000;
  endtask

  task automatic t_count();
    logic [7:0] q;
    // parallel claim held, serial claim clear: strobe must still follow counter
    chk("R10 ownership state before shifting", {exp_s, exp_b}, 5'b00010);
    for (int i = 0; i < 9; i++) begin
      logic wrap;
      wrap = (exp_c == 3'b111);
      ser_shift_en = 1'b1;
      cyc();
      ser_shift_en = 1'b0;
      exp_c = exp_c + 3'd1;
      chk(wrap ? "R7 R10 strobe on wrap" : "R7 no strobe off wrap",
          {7'd0, ser_ram_stb}, {7'd0, wrap});
      par_read(A_LO, q);
      chk("R6 counter step", q, exp_byte());
      chk("R7 strobe single cycle", {7'd0, ser_ram_stb}, 8'h00);
    end
    cyc(); cyc();
    par_read(A_LO, q);
    chk("R6 counter holds without shift", q, exp_byte());
    ser_write(A_LO, 8'hE0);
    par_write(A_LO, 8'hE2);
    ser_read(A_LO, q);
    chk("R5 counter ignores writes", q, exp_byte());
  endtask

  task automatic t_back_to_back();
    logic [7:0] q;
    ser_shift_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic wrap;
      wrap = (exp_c == 3'b111);
      cyc();
      exp_c = exp_c + 3'd1;
      chk("R7 strobe during continuous shift", {7'd0, ser_ram_stb}, {7'd0, wrap});
    end
    ser_shift_en = 1'b0;
    ser_read(A_LO, q);
    chk("R6 counter after eight shifts", q, exp_byte());
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    t_reset();
    t_ser_mask();
    t_par_mask();
    t_simul();
    t_loc();
    t_rd_old();
    t_count();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule